// File: doc/BRIEF.md
# Operand Latency Scoreboard

This block tracks, for each architectural integer register, how long ago its most recent producer issued and what kind of operation that producer was. Each cycle the issue logic presents the destinations it is issuing on a set of write slots, and asks, for each source operand of the candidate consumers, whether that operand may be used now. The answer depends on three things together: the class of the producing operation, whether a simple ALU producer ran on an execute unit or on a load/store unit, and how the consumer uses the operand (as an ordinary execute input, as the data of a store, or as a load/store address).

Every register holds one saturating countdown per use kind, loaded from a delay matrix when a producer is written. A query in the same cycle as a write sees the new producer at once, so a zero-delay pair (for example a load feeding store data) may co-issue. Register zero never waits. Operand forwarding itself lies outside this block.

Top module: `opnd_ready_sb`

## Requirements
- R1: After reset, and after any reset applied while producers are still in flight, every register reports ready for every use kind.
- R2: Use kind encoding on `rd_use`: 0 execute input, 1 store data, 2 load/store address. A producer written in cycle t with delay d makes a query of that register in cycle t+k report ready exactly when k >= d; the query in cycle t itself (k = 0) already sees the new producer.
- R3: Producer class 0 (load): delay 3 for an address use, 0 for store data, 1 for an execute input.
- R4: Producer class 1 (simple ALU) with `wr_lsu` = 0 (ran on an execute unit): delay 5 for an address use, 1 for store data and for an execute input.
- R5: Producer class 1 with `wr_lsu` = 1 (ran on a load/store unit): delay 1 for an address use, 0 for store data and for an execute input.
- R6: Producer class 2 (integer multiply): delay 7 for an address use, 3 for store data and execute inputs; `wr_lsu` has no effect for this class.
- R7: For every use kind: class 3 (basic FP op) delay 4, class 4 (fused multiply-add or second refinement step) delay 8, class 5 (move into the FP unit) delay 5, class 6 (move out of the FP unit) delay 1.
- R8: Iterative FP classes, for every use kind: 7 single divide 24, 8 double divide 32, 9 single square root 28, 10 double square root 40, 11 single reciprocal 12, 12 double reciprocal 20, 13 single reciprocal square root 16, 14 double reciprocal square root 28.
- R9: A newer write to a register replaces its older entry; when several slots write the same register in one cycle, the highest-numbered slot is the youngest and wins.
- R10: Register 0 always reports ready, and writes to it are ignored.
- R11: Use code 3 is treated as an address use, and the reserved producer class 15 takes the longest delay, 40, for every use kind.
- R12: A write to one register leaves the answer for every other register unchanged, and each query port is answered independently of the others; a ready register stays ready until it is written again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_vld | input | ISSUE_W | Write slot carries a producer this cycle |
| wr_reg | input | ISSUE_W x REG_AW | Destination register per slot |
| wr_cls | input | ISSUE_W x 4 | Producer class per slot |
| wr_lsu | input | ISSUE_W | Producer ran on a load/store unit |
| rd_reg | input | NUM_OPS x REG_AW | Queried register per operand |
| rd_use | input | NUM_OPS x 2 | Use kind per operand |
| rd_ready | output | NUM_OPS | Operand may be consumed this cycle |

## Verification
The bench builds the block with its defaults: 32 registers, two write slots and four query ports. Two slots make same-cycle writes to one register reachable, so slot priority can be observed, and four ports let all three use kinds of one register be asked in the same cycle next to an unrelated register. The 6-bit countdown derived from the 40-cycle maximum lets the longest class, and the reserved class that reuses it, run to completion.

// File: rtl/lat_sb_pkg.sv
package lat_sb_pkg;

    localparam int LAT_MAX = 40;
    localparam int CNT_W   = $clog2(LAT_MAX + 1);
    localparam int CLS_W   = 4;
    localparam int USE_W   = 2;
    localparam int NUSE    = 3;
    localparam int LANE_W  = $clog2(NUSE);

    localparam logic [LANE_W-1:0] LN_EXEC = LANE_W'(0);
    localparam logic [LANE_W-1:0] LN_STD  = LANE_W'(1);
    localparam logic [LANE_W-1:0] LN_ADDR = LANE_W'(2);

    typedef enum logic [CLS_W-1:0] {
        PC_LOAD     = 4'd0,
        PC_ALU      = 4'd1,
        PC_MUL      = 4'd2,
        PC_FP_BASIC = 4'd3,
        PC_FP_LONG  = 4'd4,
        PC_TO_FP    = 4'd5,
        PC_FROM_FP  = 4'd6,
        PC_FDIV_S   = 4'd7,
        PC_FDIV_D   = 4'd8,
        PC_FSQRT_S  = 4'd9,
        PC_FSQRT_D  = 4'd10,
        PC_FRCP_S   = 4'd11,
        PC_FRCP_D   = 4'd12,
        PC_FRSQ_S   = 4'd13,
        PC_FRSQ_D   = 4'd14,
        PC_RSVD     = 4'd15
    } prod_cls_e;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef cnt_t [NUSE-1:0]  lane_dly_t;

    // Map a consumer use code onto a countdown lane; code 3 is an address use.
    function automatic logic [LANE_W-1:0] lane_of(input logic [USE_W-1:0] use_code);
        case (use_code)
            2'd0:    return LN_EXEC;
            2'd1:    return LN_STD;
            default: return LN_ADDR;
        endcase
    endfunction

endpackage

// File: rtl/lat_sb_delay.sv
module lat_sb_delay
    import lat_sb_pkg::*;
(
    input  logic [CLS_W-1:0] cls,
    input  logic             on_lsu,
    output lane_dly_t        dly
);

    cnt_t fp_l;
    cnt_t ex_l;
    cnt_t sd_l;
    cnt_t ad_l;

    // Use-independent latencies of the FP and reserved classes.
    always_comb begin
        case (cls)
            PC_FP_BASIC: fp_l = CNT_W'(4);
            PC_FP_LONG:  fp_l = CNT_W'(8);
            PC_TO_FP:    fp_l = CNT_W'(5);
            PC_FROM_FP:  fp_l = CNT_W'(1);
            PC_FDIV_S:   fp_l = CNT_W'(24);
            PC_FDIV_D:   fp_l = CNT_W'(32);
            PC_FSQRT_S:  fp_l = CNT_W'(28);
            PC_FSQRT_D:  fp_l = CNT_W'(40);
            PC_FRCP_S:   fp_l = CNT_W'(12);
            PC_FRCP_D:   fp_l = CNT_W'(20);
            PC_FRSQ_S:   fp_l = CNT_W'(16);
            PC_FRSQ_D:   fp_l = CNT_W'(28);
            default:     fp_l = CNT_W'(LAT_MAX);
        endcase
    end

    // Integer classes split by consumer use; ALU also by the unit it ran on.
    always_comb begin
        case (cls)
            PC_LOAD: begin
                ex_l = CNT_W'(1);
                sd_l = CNT_W'(0);
                ad_l = CNT_W'(3);
            end
            PC_ALU: begin
                if (on_lsu) begin
                    ex_l = CNT_W'(0);
                    sd_l = CNT_W'(0);
                    ad_l = CNT_W'(1);
                end else begin
                    ex_l = CNT_W'(1);
                    sd_l = CNT_W'(1);
                    ad_l = CNT_W'(5);
                end
            end
            PC_MUL: begin
                ex_l = CNT_W'(3);
                sd_l = CNT_W'(3);
                ad_l = CNT_W'(7);
            end
            default: begin
                ex_l = fp_l;
                sd_l = fp_l;
                ad_l = fp_l;
            end
        endcase
        dly          = '0;
        dly[LN_EXEC] = ex_l;
        dly[LN_STD]  = sd_l;
        dly[LN_ADDR] = ad_l;
    end

endmodule

// File: rtl/lat_sb_entry.sv
module lat_sb_entry
    import lat_sb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  lane_dly_t       load_dly,
    output logic [NUSE-1:0] lane_idle
);

    typedef struct packed {
        lane_dly_t rem;
    } ent_st_t;

    ent_st_t st_d;
    ent_st_t st_q;

    // The write cycle itself counts as the first cycle of the delay.
    always_comb begin
        st_d = st_q;
        for (int l = 0; l < NUSE; l++) begin
            if (load) begin
                st_d.rem[l] = (load_dly[l] == '0) ? '0 : load_dly[l] - 1'b1;
            end else if (st_q.rem[l] != '0) begin
                st_d.rem[l] = st_q.rem[l] - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int l = 0; l < NUSE; l++) begin
            lane_idle[l] = (st_q.rem[l] == '0);
        end
    end

endmodule

// File: rtl/opnd_ready_sb.sv
module opnd_ready_sb
    import lat_sb_pkg::*;
#(
    parameter  int NUM_REGS = 32,
    parameter  int ISSUE_W  = 2,
    parameter  int NUM_OPS  = 4,
    localparam int REG_AW   = $clog2(NUM_REGS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ISSUE_W-1:0]                wr_vld,
    input  logic [ISSUE_W-1:0][REG_AW-1:0]    wr_reg,
    input  logic [ISSUE_W-1:0][CLS_W-1:0]     wr_cls,
    input  logic [ISSUE_W-1:0]                wr_lsu,
    input  logic [NUM_OPS-1:0][REG_AW-1:0]    rd_reg,
    input  logic [NUM_OPS-1:0][USE_W-1:0]     rd_use,
    output logic [NUM_OPS-1:0]                rd_ready
);

    localparam int DEPTH = 1 << REG_AW;

    lane_dly_t       slot_dly [ISSUE_W];
    logic [DEPTH-1:0] wr_hit;
    lane_dly_t       wr_sel   [DEPTH];
    logic [NUSE-1:0] cnt_idle [DEPTH];

    // One delay lookup per write slot.
    for (genvar s = 0; s < ISSUE_W; s++) begin : g_slot
        lat_sb_delay u_dly (
            .cls    (wr_cls[s]),
            .on_lsu (wr_lsu[s]),
            .dly    (slot_dly[s])
        );
    end

    // One entry per live register; register zero and unused codes are tied ready.
    for (genvar r = 0; r < DEPTH; r++) begin : g_reg
        if (r == 0 || r >= NUM_REGS) begin : g_tied
            assign wr_hit[r]   = 1'b0;
            assign wr_sel[r]   = '0;
            assign cnt_idle[r] = '1;
        end else begin : g_live
            logic      hit;
            lane_dly_t sel;

            // Later slots are younger and override earlier ones.
            always_comb begin
                hit = 1'b0;
                sel = '0;
                for (int s = 0; s < ISSUE_W; s++) begin
                    if (wr_vld[s] && (wr_reg[s] == REG_AW'(r))) begin
                        hit = 1'b1;
                        sel = slot_dly[s];
                    end
                end
            end

            assign wr_hit[r] = hit;
            assign wr_sel[r] = sel;

            lat_sb_entry u_ent (
                .clk       (clk),
                .rst_n     (rst_n),
                .load      (hit),
                .load_dly  (sel),
                .lane_idle (cnt_idle[r])
            );
        end
    end

    // A same-cycle write takes precedence over the stored countdown.
    always_comb begin
        for (int o = 0; o < NUM_OPS; o++) begin
            if (wr_hit[rd_reg[o]]) begin
                rd_ready[o] = (wr_sel[rd_reg[o]][lane_of(rd_use[o])] == '0);
            end else begin
                rd_ready[o] = cnt_idle[rd_reg[o]][lane_of(rd_use[o])];
            end
        end
    end

endmodule

// File: rtl/opnd_ready_sb_chk.sv
module opnd_ready_sb_chk
    import lat_sb_pkg::*;
#(
    parameter  int NUM_REGS = 32,
    parameter  int ISSUE_W  = 2,
    parameter  int NUM_OPS  = 4,
    localparam int REG_AW   = $clog2(NUM_REGS)
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [ISSUE_W-1:0]                wr_vld,
    input logic [ISSUE_W-1:0][REG_AW-1:0]    wr_reg,
    input logic [ISSUE_W-1:0][CLS_W-1:0]     wr_cls,
    input logic [ISSUE_W-1:0]                wr_lsu,
    input logic [NUM_OPS-1:0][REG_AW-1:0]    rd_reg,
    input logic [NUM_OPS-1:0][USE_W-1:0]     rd_use,
    input logic [NUM_OPS-1:0]                rd_ready
);

    localparam int YS = ISSUE_W - 1;

    for (genvar o = 0; o < NUM_OPS; o++) begin : g_op
        a_r10_zero_ready: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_reg[o] == '0) |-> rd_ready[o]);

        a_r12_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_ready[o] && !(|wr_vld)) |=>
            ((rd_reg[o] != $past(rd_reg[o])) || (rd_use[o] != $past(rd_use[o]))
             || (|wr_vld) || rd_ready[o]));

        // R8 as well: every class from 3 upward has a nonzero delay.
        a_r7_fp_not_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_vld[YS] && (wr_cls[YS] >= CLS_W'(3)) && (wr_reg[YS] == rd_reg[o])
             && (rd_reg[o] != '0)) |-> !rd_ready[o]);

        a_r3_load_to_stdata: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_vld[YS] && (wr_cls[YS] == CLS_W'(0)) && (wr_reg[YS] == rd_reg[o])
             && (rd_use[o] == USE_W'(1))) |-> rd_ready[o]);
    end

    a_r6_mul_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld[YS] && (wr_cls[YS] == CLS_W'(2)) && (wr_reg[YS] != '0)) |=>
        ((rd_reg[0] != $past(wr_reg[YS])) || (|wr_vld) || !rd_ready[0]));

endmodule

bind opnd_ready_sb opnd_ready_sb_chk #(
    .NUM_REGS (NUM_REGS),
    .ISSUE_W  (ISSUE_W),
    .NUM_OPS  (NUM_OPS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_vld   (wr_vld),
    .wr_reg   (wr_reg),
    .wr_cls   (wr_cls),
    .wr_lsu   (wr_lsu),
    .rd_reg   (rd_reg),
    .rd_use   (rd_use),
    .rd_ready (rd_ready)
);

// File: tb/opnd_ready_sb_tb.sv
module opnd_ready_sb_tb;
    import lat_sb_pkg::*;

    localparam int NUM_REGS = 32;
    localparam int ISSUE_W  = 2;
    localparam int NUM_OPS  = 4;
    localparam int REG_AW   = 5;

    logic                           clk = 1'b0;
    logic                           rst_n = 1'b0;
    logic [ISSUE_W-1:0]             wr_vld = '0;
    logic [ISSUE_W-1:0][REG_AW-1:0] wr_reg = '0;
    logic [ISSUE_W-1:0][CLS_W-1:0]  wr_cls = '0;
    logic [ISSUE_W-1:0]             wr_lsu = '0;
    logic [NUM_OPS-1:0][REG_AW-1:0] rd_reg = '0;
    logic [NUM_OPS-1:0][USE_W-1:0]  rd_use = '0;
    logic [NUM_OPS-1:0]             rd_ready;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    opnd_ready_sb #(
        .NUM_REGS (NUM_REGS),
        .ISSUE_W  (ISSUE_W),
        .NUM_OPS  (NUM_OPS)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_vld   (wr_vld),
        .wr_reg   (wr_reg),
        .wr_cls   (wr_cls),
        .wr_lsu   (wr_lsu),
        .rd_reg   (rd_reg),
        .rd_use   (rd_use),
        .rd_ready (rd_ready)
    );

    // {class[17:14], lsu[13], use[12:11], expected delay[10:5], register[4:0]}
    localparam int NVEC = 27;
    localparam logic [17:0] VEC [NVEC] = '{
        {4'd0,  1'b0, 2'd0, 6'd1,  5'd1},
        {4'd0,  1'b0, 2'd1, 6'd0,  5'd2},
        {4'd0,  1'b0, 2'd2, 6'd3,  5'd3},
        {4'd0,  1'b0, 2'd3, 6'd3,  5'd4},
        {4'd1,  1'b0, 2'd0, 6'd1,  5'd5},
        {4'd1,  1'b0, 2'd1, 6'd1,  5'd6},
        {4'd1,  1'b0, 2'd2, 6'd5,  5'd7},
        {4'd1,  1'b1, 2'd0, 6'd0,  5'd8},
        {4'd1,  1'b1, 2'd1, 6'd0,  5'd10},
        {4'd1,  1'b1, 2'd2, 6'd1,  5'd11},
        {4'd2,  1'b0, 2'd0, 6'd3,  5'd12},
        {4'd2,  1'b0, 2'd1, 6'd3,  5'd13},
        {4'd2,  1'b0, 2'd2, 6'd7,  5'd14},
        {4'd2,  1'b1, 2'd2, 6'd7,  5'd15},
        {4'd3,  1'b0, 2'd0, 6'd4,  5'd16},
        {4'd4,  1'b0, 2'd2, 6'd8,  5'd17},
        {4'd5,  1'b0, 2'd1, 6'd5,  5'd18},
        {4'd6,  1'b0, 2'd0, 6'd1,  5'd19},
        {4'd7,  1'b0, 2'd0, 6'd24, 5'd21},
        {4'd8,  1'b0, 2'd2, 6'd32, 5'd22},
        {4'd9,  1'b0, 2'd1, 6'd28, 5'd23},
        {4'd10, 1'b0, 2'd0, 6'd40, 5'd24},
        {4'd11, 1'b0, 2'd0, 6'd12, 5'd25},
        {4'd12, 1'b0, 2'd2, 6'd20, 5'd26},
        {4'd13, 1'b0, 2'd1, 6'd16, 5'd27},
        {4'd14, 1'b0, 2'd0, 6'd28, 5'd28},
        {4'd15, 1'b0, 2'd0, 6'd40, 5'd29}
    };

    function automatic string tag_of(input int c, input int l, input int u);
        if (u == 3 || c == 15) return "R11";
        if (c == 0) return "R3";
        if (c == 1) return (l != 0) ? "R5" : "R4";
        if (c == 2) return "R6";
        if (c <= 6) return "R7";
        return "R8";
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Write up to two slots, then count cycles until port 0 reports ready.
    task automatic measure(input int c0, input int l0, input int r0,
                           input bit v1, input int c1, input int l1, input int r1,
                           input int qr, input int qu, output int k);
        @(negedge clk);
        wr_vld    = '0;
        wr_vld[0] = 1'b1;
        wr_reg[0] = REG_AW'(r0);
        wr_cls[0] = CLS_W'(c0);
        wr_lsu[0] = l0[0];
        wr_vld[1] = v1;
        wr_reg[1] = REG_AW'(r1);
        wr_cls[1] = CLS_W'(c1);
        wr_lsu[1] = l1[0];
        rd_reg[0] = REG_AW'(qr);
        rd_use[0] = USE_W'(qu);
        #1;
        k = rd_ready[0] ? 0 : -1;
        for (int c = 1; c <= 60 && k < 0; c++) begin
            @(negedge clk);
            wr_vld = '0;
            #1;
            if (rd_ready[0]) k = c;
        end
        wr_vld = '0;
    endtask

    initial begin
        int k;
        repeat (3) @(posedge clk);
        @(negedge clk);

        // R1: state straight out of reset, all use kinds.
        for (int o = 0; o < NUM_OPS; o++) begin
            rd_reg[o] = REG_AW'(3 + 7 * o);
            rd_use[o] = USE_W'(o);
        end
        #1;
        check(rd_ready == '1, "R1", "ready after reset", int'(rd_ready), 15);
        rst_n = 1'b1;

        // R2 timing model over the whole delay matrix.
        for (int i = 0; i < NVEC; i++) begin
            int c, l, u, e, r;
            c = int'(VEC[i][17:14]);
            l = int'(VEC[i][13]);
            u = int'(VEC[i][12:11]);
            e = int'(VEC[i][10:5]);
            r = int'(VEC[i][4:0]);
            measure(c, l, r, 1'b0, 0, 0, 0, r, u, k);
            check(k == e, tag_of(c, l, u), $sformatf("R2 delay class %0d lsu %0d use %0d", c, l, u), k, e);
        end
        wr_vld = '0;
        repeat (50) @(negedge clk);

        // R10: multiply into register zero, address use, same cycle.
        measure(2, 0, 0, 1'b0, 0, 0, 0, 0, 2, k);
        check(k == 0, "R10", "register zero ready", k, 0);

        // R9: same-cycle writes, youngest slot wins.
        measure(10, 0, 6, 1'b1, 1, 1, 6, 6, 0, k);
        check(k == 0, "R9", "slot1 short producer wins", k, 0);
        measure(1, 1, 6, 1'b1, 7, 0, 6, 6, 0, k);
        check(k == 24, "R9", "slot1 long producer wins", k, 24);

        // R9: a newer write replaces an in-flight long producer.
        @(negedge clk);
        wr_vld    = 2'b01;
        wr_reg[0] = 5'd5;
        wr_cls[0] = 4'd8;
        wr_lsu[0] = 1'b0;
        @(negedge clk);
        wr_vld    = 2'b10;
        wr_reg[1] = 5'd5;
        wr_cls[1] = 4'd1;
        wr_lsu[1] = 1'b1;
        rd_reg[0] = 5'd5;
        rd_use[0] = 2'd0;
        rd_reg[1] = 5'd5;
        rd_use[1] = 2'd2;
        #1;
        check(rd_ready[0] == 1'b1, "R9", "replaced entry exec use", int'(rd_ready[0]), 1);
        check(rd_ready[1] == 1'b0, "R9", "replaced entry address use", int'(rd_ready[1]), 0);
        @(negedge clk);
        wr_vld = '0;
        #1;
        check(rd_ready[1:0] == 2'b11, "R9", "replaced entry one cycle later", int'(rd_ready[1:0]), 3);

        // R12: another register is unaffected by a write in the same cycle.
        measure(10, 0, 7, 1'b1, 2, 0, 8, 30, 2, k);
        check(k == 0, "R12", "unrelated register stays ready", k, 0);
        repeat (50) @(negedge clk);

        // R6 and R12: four ports on one multiply result and a bystander.
        @(negedge clk);
        wr_vld    = 2'b01;
        wr_reg[0] = 5'd11;
        wr_cls[0] = 4'd2;
        wr_lsu[0] = 1'b0;
        rd_reg    = {5'd12, 5'd11, 5'd11, 5'd11};
        rd_use    = {2'd2, 2'd2, 2'd1, 2'd0};
        #1;
        check(rd_ready == 4'b1000, "R12", "ports in write cycle", int'(rd_ready), 8);
        @(negedge clk);
        wr_vld = '0;
        @(negedge clk);
        #1;
        check(rd_ready == 4'b1000, "R6", "ports two cycles on", int'(rd_ready), 8);
        @(negedge clk);
        #1;
        check(rd_ready == 4'b1011, "R6", "ports three cycles on", int'(rd_ready), 11);
        repeat (4) @(negedge clk);
        #1;
        check(rd_ready == 4'b1111, "R6", "ports seven cycles on", int'(rd_ready), 15);

        // R1: reset while two long producers are in flight.
        @(negedge clk);
        wr_vld    = 2'b11;
        wr_reg[0] = 5'd20;
        wr_cls[0] = 4'd8;
        wr_reg[1] = 5'd9;
        wr_cls[1] = 4'd10;
        wr_lsu    = '0;
        @(negedge clk);
        wr_vld    = '0;
        rd_reg[0] = 5'd9;
        rd_use[0] = 2'd2;
        rd_reg[1] = 5'd20;
        rd_use[1] = 2'd0;
        #1;
        check(rd_ready[1:0] == 2'b00, "R1", "busy before reset", int'(rd_ready[1:0]), 0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(rd_ready[1:0] == 2'b11, "R1", "ready after mid-flight reset", int'(rd_ready[1:0]), 3);

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R2 watchdog expired: actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule